// File: doc/BRIEF.md
# Transmit Byte Queue with Fill-Level Trigger Flag

This block is a small first-in first-out store that sits between software and a serial transmit engine. Software pushes bytes through a write port. The serial engine pulls them one at a time through a read port. The queue reports how many bytes it holds and how many slots are free.

A two-bit trigger selector picks a low-water level. While the fill count is at or below that level, a sticky "room available" flag is raised. Software can then write as many bytes as there are free slots without stalling the transmitter. Software may clear the flag by writing a zero to it; a written one has no effect. If the fill count is still at or below the level, the flag comes straight back on the next edge.

Writes to a full queue are discarded and latch an overflow error. Reads from an empty queue leave the output byte and the count as they were. A synchronous flush empties the queue and clears the error.

Top module: `txq_fifo`

## Requirements
- R1: After reset, count is 0, space equals DEPTH, empty is 1, full is 0, overflow is 0, rd_data is 0 and the trigger flag is 1.
- R2: On the clock edge where an accepted push occurs without a pop, count rises by one. An accepted pop without a push lowers it by one. An accepted push together with an accepted pop leaves count unchanged.
- R3: Bytes leave through rd_data in the order they were pushed. rd_data is updated on the edge that accepts the pop.
- R4: A write while full (count equals DEPTH) is dropped: count stays at DEPTH and overflow becomes 1. Overflow stays 1 until a flush.
- R5: A read while empty leaves rd_data holding the last popped byte and keeps count at 0.
- R6: Trigger selector codes 0, 1, 2 and 3 select levels 0, 2, 4 and 8 bytes. The flag is 1 after any edge at which count (before that edge) was at or below the selected level.
- R7: A flag write with data 0 clears the flag when count is above the level. A flag write with data 1 leaves the flag unchanged.
- R8: A flag clear in a cycle where count is at or below the level is overridden: the flag stays 1.
- R9: Flush empties the queue (count 0) and clears overflow on its edge. It overrides a push or pop in the same cycle. The flag is set on the following edge.
- R10: space always equals DEPTH minus count. full is 1 exactly when count equals DEPTH. empty is 1 exactly when count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue and clear overflow |
| wr_en | input | 1 | Push request from software |
| wr_data | input | DATA_W | Byte to push |
| rd_en | input | 1 | Pop request from the serial engine |
| rd_data | output | DATA_W | Last popped byte |
| trig_sel | input | 2 | Trigger level code: 0, 1, 2, 3 select levels 0, 2, 4, 8 |
| flag_wr | input | 1 | Software write strobe to the trigger flag |
| flag_wdata | input | 1 | Value written to the flag (0 clears, 1 ignored) |
| trig_flag | output | 1 | Sticky room-available flag |
| count | output | CNT_W | Bytes currently held |
| space | output | CNT_W | Free slots |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | Sticky error: a push was dropped because the queue was full |

## Verification
The bench uses the default parameters: DEPTH of 16 and DATA_W of 8. With these values the full boundary is reached after sixteen pushes, so overflow, pointer wrap and full-queue ordering are all exercised in a short run. The 8-byte trigger level is also below full at this depth. As a result, every trigger code can be driven both above and below its level, which lets the bench exercise the clear-overridden case and the clear-accepted case for each code.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Low-water level selected by a 2-bit code: 0 -> 0, n -> 2^n, clipped to depth.
  function automatic int unsigned trig_level(input logic [1:0] code,
                                             input int unsigned depth);
    int unsigned lv;
    lv = (code == 2'd0) ? 0 : (32'd1 << code);
    if (lv > depth) lv = depth;
    return lv;
  endfunction

  // Circular pointer advance for an arbitrary depth.
  function automatic int unsigned ptr_advance(input int unsigned p,
                                              input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             overflow
);
  import txq_pkg::*;

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign push_ok = wr_en & ~full & ~flush;
  assign pop_ok  = rd_en & ~empty & ~flush;

  logic [PTR_W-1:0] wptr_nxt, rptr_nxt;
  assign wptr_nxt = PTR_W'(ptr_advance(int'(wptr), DEPTH));
  assign rptr_nxt = PTR_W'(ptr_advance(int'(rptr), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr_nxt;
      if (pop_ok)  rptr <= rptr_nxt;
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  overflow <= 1'b0;
    else if (flush)              overflow <= 1'b0;
    else if (wr_en && full)      overflow <= 1'b1;
  end

endmodule

// File: rtl/txq_storage.sv
module txq_storage #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_ok,
  input  logic              pop_ok,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  slot_we;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot_dec
    assign slot_we[i] = push_ok && (wptr == PTR_W'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (pop_ok) rd_data <= mem[rptr];
  end

endmodule

// File: rtl/txq_trigger.sv
module txq_trigger #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       trig_sel,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic [CNT_W-1:0] level,
  output logic             at_or_below,
  output logic             clr_req,
  output logic             trig_flag
);
  import txq_pkg::*;

  assign level       = CNT_W'(trig_level(trig_sel, DEPTH));
  assign at_or_below = (count <= level);
  assign clr_req     = flag_wr & ~flag_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)           trig_flag <= 1'b1;
    else if (at_or_below) trig_flag <= 1'b1;
    else if (clr_req)     trig_flag <= 1'b0;
  end

endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        trig_sel,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  output logic              trig_flag,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  space,
  output logic              full,
  output logic              empty,
  output logic              overflow
);

  logic [PTR_W-1:0] wptr, rptr;
  logic             push_ok, pop_ok;
  logic [CNT_W-1:0] level;
  logic             at_or_below, clr_req;

  txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
    .wptr(wptr), .rptr(rptr), .count(count), .full(full), .empty(empty),
    .push_ok(push_ok), .pop_ok(pop_ok), .overflow(overflow)
  );

  txq_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .wptr(wptr), .rptr(rptr), .wr_data(wr_data), .rd_data(rd_data)
  );

  txq_trigger #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .rst_n(rst_n), .count(count), .trig_sel(trig_sel),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .level(level),
    .at_or_below(at_or_below), .clr_req(clr_req), .trig_flag(trig_flag)
  );

  assign space = CNT_W'(DEPTH) - count;

endmodule

// File: rtl/txq_fifo_chk.sv
module txq_fifo_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              flag_wr,
  input logic              flag_wdata,
  input logic              trig_flag,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  space,
  input logic              full,
  input logic              empty,
  input logic              overflow,
  input logic              push_ok,
  input logic              pop_ok,
  input logic              at_or_below
);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_push_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));

  assert_pair_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (count == $past(count)));

  assert_no_overflow_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !flush) |=> (full && overflow));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en && !flush) |=> ($stable(rd_data) && empty));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    at_or_below |=> trig_flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !(flag_wr && !flag_wdata)) |=> trig_flag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata && !at_or_below) |=> !trig_flag);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !overflow));

  assert_space_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (space + count == CNT_W'(DEPTH)) && (full == (count == CNT_W'(DEPTH)))
    && (empty == (count == '0)));

endmodule

bind txq_fifo txq_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .trig_flag(trig_flag), .count(count), .space(space), .full(full),
  .empty(empty), .overflow(overflow), .push_ok(push_ok), .pop_ok(pop_ok),
  .at_or_below(at_or_below)
);

// File: tb/txq_fifo_tb.sv
module txq_fifo_tb;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 0, wr_en = 0, rd_en = 0, flag_wr = 0, flag_wdata = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0] trig_sel = 2'd0;
  logic [DATA_W-1:0] rd_data;
  logic trig_flag, full, empty, overflow;
  logic [CNT_W-1:0] count, space;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  txq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .trig_sel(trig_sel), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .trig_flag(trig_flag), .count(count),
    .space(space), .full(full), .empty(empty), .overflow(overflow)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] data;
    logic       rd;
    logic [4:0] exp_cnt;
    logic       chk_rd;
    logic [7:0] exp_rd;
  } vec_t;

  // R2/R3/R5 stream: push, pop, push+pop, pop on empty
  localparam int NVEC = 10;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 8'hA1, 1'b0, 5'd1, 1'b0, 8'h00},
    '{1'b1, 8'hB2, 1'b0, 5'd2, 1'b0, 8'h00},
    '{1'b1, 8'hC3, 1'b0, 5'd3, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 5'd2, 1'b1, 8'hA1},
    '{1'b1, 8'hD4, 1'b1, 5'd2, 1'b1, 8'hB2},
    '{1'b0, 8'h00, 1'b1, 5'd1, 1'b1, 8'hC3},
    '{1'b0, 8'h00, 1'b1, 5'd0, 1'b1, 8'hD4},
    '{1'b0, 8'h00, 1'b1, 5'd0, 1'b1, 8'hD4},
    '{1'b1, 8'hE5, 1'b0, 5'd1, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 5'd0, 1'b1, 8'hE5}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic fw, input logic fd, input logic fl);
    wr_en = w; wr_data = d; rd_en = r; flag_wr = fw; flag_wdata = fd; flush = fl;
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; flag_wr = 0; flag_wdata = 0; flush = 0;
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 space", int'(space), DEPTH);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 flag", int'(trig_flag), 1);

    // Table walk: R2 counting, R3 order, R5 empty read
    for (int i = 0; i < NVEC; i++) begin
      step(TBL[i].wr, TBL[i].data, TBL[i].rd, 1'b0, 1'b0, 1'b0);
      chk("R2 count", int'(count), int'(TBL[i].exp_cnt));
      if (TBL[i].chk_rd) chk("R3/R5 rd_data", int'(rd_data), int'(TBL[i].exp_rd));
    end

    // Trigger level 4 (code 2): R6, R7, R8
    trig_sel = 2'd2;
    for (int i = 0; i < 5; i++) step(1'b1, 8'(i), 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 count five", int'(count), 5);
    chk("R6 flag sticky", int'(trig_flag), 1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 clear above level", int'(trig_flag), 0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 write one ignored", int'(trig_flag), 0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 count 4", int'(count), 4);
    chk("R6 flag not yet", int'(trig_flag), 0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 flag at level 4", int'(trig_flag), 1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 clear overridden", int'(trig_flag), 1);

    // Code 3 (level 8): count 4 within level
    trig_sel = 2'd3;
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 level 8 overrides clear", int'(trig_flag), 1);
    // Code 1 (level 2): count 4 above level
    trig_sel = 2'd1;
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 level 2 clear", int'(trig_flag), 0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6 count 2", int'(count), 2);
    chk("R6 flag lag", int'(trig_flag), 0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 flag at level 2", int'(trig_flag), 1);
    // Code 0 (level 0): count 2 above level
    trig_sel = 2'd0;
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 level 0 clear", int'(trig_flag), 0);

    // Fill to full, overflow, flush: R4, R9, R10
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 flush count", int'(count), 0);
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'd3 + 8'(i * 7)), 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 full", int'(full), 1);
    chk("R10 space zero", int'(space), 0);
    chk("R4 no overflow yet", int'(overflow), 0);
    step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 count held", int'(count), DEPTH);
    chk("R4 overflow set", int'(overflow), 1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 overflow sticky", int'(overflow), 1);
    chk("R3 first out", int'(rd_data), 3);
    step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 clear when full", int'(trig_flag), 0);
    step(1'b1, 8'h55, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R9 flush overrides", int'(count), 0);
    chk("R9 overflow cleared", int'(overflow), 0);
    chk("R9 flag next edge", int'(trig_flag), 0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 flag set", int'(trig_flag), 1);

    // Full ordering with wrap: R3
    for (int i = 0; i < 5; i++) step(1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h40 + 8'(i)), 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R3 wrapped order", int'(rd_data), 'h40 + i);
      chk("R10 space", int'(space), i + 1);
    end
    chk("R10 empty", int'(empty), 1);

    summary();
    $finish;
  end

endmodule